// File: doc/BRIEF.md
# Transfer Request Packet Sequencer

This block steps through the transfer-request records held in one descriptor. A one-cycle `start` pulse presents two header words. The block checks the header, and if it is sound it hands out record numbers one at a time on a valid/ready channel. Each record number comes with its byte offset from the start of the descriptor. A downstream fetch engine turns that offset into a memory read. The block does not fetch, decode or move data, and it does not push anything onto a queue.

When the final record of the list has been taken, the reload count decides what happens next. A count of zero ends the packet and asks for the descriptor to be returned. A count between 1 and 510 sends the walk back to a programmable reload record, and each such jump uses up one pass. The all-ones count of 511 loops forever. A synchronous `stop` input ends any run once the record currently offered has been taken.

Top module: `trq_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `rec_valid`, `done`, `ret_desc` and `cfg_err` are all 0.
- R2: The header type is `hdr_word0[31:30]`, and only code 3 is accepted. Any other type makes `cfg_err` pulse for one cycle after the start cycle, and the block stays idle.
- R3: The reload record index is `hdr_word0[19:14]` and the final record index is `hdr_word0[13:0]`. If the reload index is greater than the final index, the start is rejected with a `cfg_err` pulse and the block stays idle.
- R4: The size code is `hdr_word1[26:24]`. Codes 0, 1, 2 and 3 give records of 16, 32, 64 and 128 bytes. Codes 4 to 7 are rejected with `cfg_err`. All other header bits, including `hdr_word0[29]` and the rest of `hdr_word1`, have no effect.
- R5: Records are offered in rising order starting at 0. Record i is offered with `rec_offset` = (i+1) × record size, because the first slot holds the packet header.
- R6: While `rec_valid` is high and `rec_ready` is low, `rec_index` and `rec_offset` hold their values.
- R7: The reload count is `hdr_word0[28:20]`. With a count of 0, the handshake on the final record ends the run, and `done` and `ret_desc` pulse together for one cycle in the next cycle.
- R8: With a count N from 1 to 510, the walk continues at the reload index after the final record, N times. That gives (last+1) + N×(last−reload+1) records in total, and the run then ends with `done` and `ret_desc`.
- R9: A count of 511 repeats the section from the reload index to the final record without end.
- R10: If `stop` is high at any time during a run, the run ends at the next handshake, which may fall in the same cycle. `done` then pulses and `ret_desc` stays 0.
- R11: A `start` pulse while the block is busy has no effect on the run in progress.
- R12: A `stop` pulse while the block is idle has no effect, and a later run behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the header words and begin a run |
| hdr_word0 | input | 32 | Header word: type, reload count, reload index, final index |
| hdr_word1 | input | 32 | Header word holding the record-size code |
| stop | input | 1 | End the run after the record in flight |
| rec_valid | output | 1 | A record index is offered |
| rec_ready | input | 1 | The downstream side takes the offered record |
| rec_index | output | 14 | Number of the offered record |
| rec_offset | output | 22 | Byte offset of the offered record |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| ret_desc | output | 1 | One-cycle pulse asking for the descriptor to be returned |
| cfg_err | output | 1 | One-cycle pulse when a header is rejected |

## Verification
On every cycle, the assertions check that the offered record holds steady under backpressure and never passes the final index. They check that a wrap lands on the reload index, that a stop always ends the run without a return request, that rejection and an ignored start never disturb the state, and that offsets stay aligned. Only the bench scenarios can show the full order of records and their exact offsets, the total number of passes for each reload count, and the choice between a return request and a plain stop. They also show that the all-ones count keeps looping until it is stopped.

// File: rtl/trq_pkg.sv
package trq_pkg;

    localparam int TYPE_HI   = 31;
    localparam int TYPE_LO   = 30;
    localparam int CNT_HI    = 28;
    localparam int CNT_LO    = 20;
    localparam int RLD_HI    = 19;
    localparam int RLD_LO    = 14;
    localparam int LAST_HI   = 13;
    localparam int LAST_LO   = 0;
    localparam int SZC_HI    = 26;
    localparam int SZC_LO    = 24;

    localparam int IDX_W     = LAST_HI - LAST_LO + 1;
    localparam int RLD_W     = RLD_HI - RLD_LO + 1;
    localparam int CNT_W     = CNT_HI - CNT_LO + 1;
    localparam int SZC_W     = 2;
    localparam int NUM_SIZES = 1 << SZC_W;
    localparam int BASE_SH   = 4;
    localparam int OFF_W     = IDX_W + 1 + BASE_SH + NUM_SIZES - 1;

    localparam logic [1:0]       TYPE_TRQ  = 2'd3;
    localparam logic [CNT_W-1:0] CNT_ENDLESS = '1;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} walk_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] last;
        logic [RLD_W-1:0] rld;
        logic [CNT_W-1:0] cnt;
        logic [SZC_W-1:0] szc;
    } trq_cfg_t;

    function automatic logic [OFF_W-1:0] rec_off(input logic [IDX_W-1:0] idx,
                                                 input int unsigned sh);
        logic [OFF_W-1:0] base;
        base = OFF_W'({1'b0, idx} + (IDX_W+1)'(1));
        return base << sh;
    endfunction

endpackage

// File: rtl/trq_hdr_decode.sv
module trq_hdr_decode
    import trq_pkg::*;
(
    input  logic [31:0] hdr_word0,
    input  logic [31:0] hdr_word1,
    output trq_cfg_t    cfg,
    output logic        cfg_ok
);
    logic [1:0]        hdr_type;
    logic [2:0]        szc_full;
    logic              hdr_unused;

    assign hdr_type   = hdr_word0[TYPE_HI:TYPE_LO];
    assign szc_full   = hdr_word1[SZC_HI:SZC_LO];
    assign hdr_unused = ^{hdr_word0[29], hdr_word1[31:27], hdr_word1[23:0]};

    assign cfg.last = hdr_word0[LAST_HI:LAST_LO];
    assign cfg.rld  = hdr_word0[RLD_HI:RLD_LO];
    assign cfg.cnt  = hdr_word0[CNT_HI:CNT_LO];
    assign cfg.szc  = szc_full[SZC_W-1:0];

    always_comb begin
        cfg_ok = 1'b1;
        if (hdr_type != TYPE_TRQ)                   cfg_ok = 1'b0;
        if (IDX_W'(cfg.rld) > cfg.last)             cfg_ok = 1'b0;
        if (szc_full[2] != 1'b0)                    cfg_ok = 1'b0;
    end
endmodule

// File: rtl/trq_offset_calc.sv
module trq_offset_calc
    import trq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [SZC_W-1:0] szc,
    output logic [OFF_W-1:0] offset
);
    logic [OFF_W-1:0] cand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign cand[g] = rec_off(idx, BASE_SH + g);
    end

    assign offset = cand[szc];
endmodule

// File: rtl/trq_walker.sv
module trq_walker
    import trq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  trq_cfg_t         cfg_in,
    input  logic             cfg_ok,
    input  logic             stop,
    input  logic             rec_ready,
    output logic             rec_valid,
    output logic [IDX_W-1:0] cur_idx,
    output logic [SZC_W-1:0] cur_szc,
    output logic             busy,
    output logic             done,
    output logic             ret_desc,
    output logic             cfg_err
);
    walk_state_t      state;
    trq_cfg_t         cfg_q;
    logic [IDX_W-1:0] cur;
    logic [CNT_W-1:0] passes;
    logic             stop_q, done_q, ret_q, err_q;
    logic             hs, at_last, halt;

    assign rec_valid = (state == ST_RUN);
    assign busy      = (state == ST_RUN);
    assign hs        = rec_valid && rec_ready;
    assign at_last   = (cur == cfg_q.last);
    assign halt      = stop || stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg_q  <= '0;
            cur    <= '0;
            passes <= '0;
            stop_q <= 1'b0;
            done_q <= 1'b0;
            ret_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ret_q  <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            cfg_q  <= cfg_in;
                            cur    <= '0;
                            passes <= cfg_in.cnt;
                            stop_q <= 1'b0;
                            state  <= ST_RUN;
                        end else begin
                            err_q  <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (stop) stop_q <= 1'b1;
                    if (hs) begin
                        if (halt) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            stop_q <= 1'b0;
                        end else if (at_last) begin
                            if (cfg_q.cnt == CNT_ENDLESS) begin
                                cur <= IDX_W'(cfg_q.rld);
                            end else if (passes != '0) begin
                                passes <= passes - 1'b1;
                                cur    <= IDX_W'(cfg_q.rld);
                            end else begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                                ret_q  <= 1'b1;
                            end
                        end else begin
                            cur <= cur + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_idx  = cur;
    assign cur_szc  = cfg_q.szc;
    assign done     = done_q;
    assign ret_desc = ret_q;
    assign cfg_err  = err_q;

    // R6: offered record held under backpressure
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(cur_idx)));

    // R5: never beyond the final record
    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (cur_idx <= cfg_q.last));

    // R7: a return request always comes with done
    p_ret_done_r7: assert property (@(posedge clk) disable iff (rst)
        ret_desc |-> done);

    // R8: a wrap lands on the reload record
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (hs && at_last && !halt && (passes != '0 || cfg_q.cnt == CNT_ENDLESS))
        |=> (rec_valid && cur_idx == IDX_W'(cfg_q.rld)));

    // R10: a stop ends the run without a return request
    p_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (hs && halt) |=> (done && !ret_desc && !busy));

    // R2: a rejected header leaves the block idle
    p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    // R11: start during a run does not restart it
    p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !rec_ready) |=> (busy && $stable(cur_idx) && !cfg_err));
endmodule

// File: rtl/trq_sequencer.sv
module trq_sequencer
    import trq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      hdr_word0,
    input  logic [31:0]      hdr_word1,
    input  logic             stop,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [IDX_W-1:0] rec_index,
    output logic [OFF_W-1:0] rec_offset,
    output logic             busy,
    output logic             done,
    output logic             ret_desc,
    output logic             cfg_err
);
    trq_cfg_t         cfg;
    logic             cfg_ok;
    logic [SZC_W-1:0] szc;

    trq_hdr_decode u_dec (
        .hdr_word0 (hdr_word0),
        .hdr_word1 (hdr_word1),
        .cfg       (cfg),
        .cfg_ok    (cfg_ok)
    );

    trq_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg),
        .cfg_ok    (cfg_ok),
        .stop      (stop),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .cur_idx   (rec_index),
        .cur_szc   (szc),
        .busy      (busy),
        .done      (done),
        .ret_desc  (ret_desc),
        .cfg_err   (cfg_err)
    );

    trq_offset_calc u_off (
        .idx    (rec_index),
        .szc    (szc),
        .offset (rec_offset)
    );

    // R4: offsets are whole 16-byte slots
    p_align_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_offset[BASE_SH-1:0] == '0));

    // R5: record slot 0 holds the header, so no record sits at offset 0
    p_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_offset != '0));
endmodule

// File: tb/tb_trq_sequencer.sv
module tb_trq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, stop = 1'b0, rec_ready = 1'b0;
    logic [31:0] hdr_word0 = '0, hdr_word1 = '0;
    logic        rec_valid, busy, done, ret_desc, cfg_err;
    logic [13:0] rec_index;
    logic [21:0] rec_offset;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    trq_sequencer dut (
        .clk(clk), .rst(rst), .start(start), .hdr_word0(hdr_word0),
        .hdr_word1(hdr_word1), .stop(stop), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_index(rec_index), .rec_offset(rec_offset),
        .busy(busy), .done(done), .ret_desc(ret_desc), .cfg_err(cfg_err)
    );

    function automatic logic [31:0] mk0(input int t, input int cnt, input int rld, input int last);
        logic [1:0] tt; logic [8:0] cc; logic [5:0] rr; logic [13:0] ll;
        tt = 2'(t); cc = 9'(cnt); rr = 6'(rld); ll = 14'(last);
        return {tt, 1'b0, cc, rr, ll};
    endfunction

    function automatic logic [31:0] mk1(input int code);
        logic [2:0] c;
        c = 3'(code);
        return {5'b10101, c, 24'h5AC3F0};
    endfunction

    typedef struct packed {
        logic [31:0] h0;
        logic [31:0] h1;
        logic [15:0] stop_at;
        logic [15:0] stray_at;
        logic        stall;
        logic        exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{mk0(3,   0, 0, 3), mk1(0), 16'd0,  16'd0, 1'b0, 1'b0},  // R5 R7
        '{mk0(3,   2, 1, 3), mk1(1), 16'd0,  16'd0, 1'b1, 1'b0},  // R6 R8
        '{mk0(3,   1, 3, 3), mk1(3), 16'd0,  16'd0, 1'b0, 1'b0},  // R8 reload==last
        '{mk0(3, 511, 2, 4), mk1(2), 16'd13, 16'd0, 1'b0, 1'b0},  // R9 R10
        '{mk0(3,   0, 0, 0), mk1(3), 16'd0,  16'd0, 1'b0, 1'b0},  // R4 single record
        '{mk0(1,   0, 0, 3), mk1(0), 16'd0,  16'd0, 1'b0, 1'b1},  // R2
        '{mk0(3,   1, 5, 3), mk1(0), 16'd0,  16'd0, 1'b0, 1'b1},  // R3
        '{mk0(3,   0, 0, 3), mk1(5), 16'd0,  16'd0, 1'b0, 1'b1},  // R4
        '{mk0(2,   0, 0, 3), mk1(0), 16'd0,  16'd0, 1'b0, 1'b1},  // R2
        '{mk0(3, 510, 0, 0), mk1(2), 16'd0,  16'd0, 1'b0, 1'b0},  // R8 max count
        '{mk0(3,   0, 0, 5), mk1(0), 16'd0,  16'd2, 1'b0, 1'b0},  // R11
        '{mk0(3,   3, 0, 2), mk1(1), 16'd1,  16'd0, 1'b0, 1'b0},  // R10 counted
        '{mk0(3, 511, 0, 0), mk1(0), 16'd40, 16'd0, 1'b1, 1'b0}   // R9 R6
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int vi, input vec_t v);
        int last, rld, cnt, szc, exp_n, n, exp_i, passes, guard;
        bit fin, saw_err, saw_ret, stl;
        longint exp_off;
        last = int'(v.h0[13:0]); rld = int'(v.h0[19:14]);
        cnt = int'(v.h0[28:20]); szc = int'(v.h1[25:24]);
        exp_n = (v.stop_at != 0) ? int'(v.stop_at) : (last + 1) + cnt * (last - rld + 1);
        n = 0; exp_i = 0; passes = cnt; guard = 0;
        fin = 0; saw_err = 0; saw_ret = 0;
        @(negedge clk);
        hdr_word0 = v.h0; hdr_word1 = v.h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.exp_err) begin
            check(cfg_err == 1'b1, "R2/R3/R4 reject", $sformatf("vec %0d cfg_err", vi), cfg_err, 1);
            check(busy == 1'b0 && rec_valid == 1'b0, "R2 idle after reject",
                  $sformatf("vec %0d busy", vi), busy, 0);
            @(negedge clk);
            check(cfg_err == 1'b0, "R2 pulse width", $sformatf("vec %0d cfg_err", vi), cfg_err, 0);
            return;
        end
        while (!fin && guard < 20000) begin
            guard++;
            if (cfg_err) saw_err = 1;
            if (done) begin
                fin = 1;
                saw_ret = ret_desc;
            end else if (rec_valid) begin
                stl = v.stall && (guard % 3 == 1);
                exp_off = longint'(exp_i + 1) << (4 + szc);
                check(int'(rec_index) == exp_i, stl ? "R6 hold" : "R5/R8/R9 order",
                      $sformatf("vec %0d rec %0d index", vi, n), rec_index, exp_i);
                check(longint'(rec_offset) == exp_off, "R4/R5 offset",
                      $sformatf("vec %0d rec %0d offset", vi, n), rec_offset, exp_off);
                if (!stl) begin
                    rec_ready = 1'b1;
                    n++;
                    stop = (v.stop_at != 0 && n == int'(v.stop_at));
                    start = (v.stray_at != 0 && n == int'(v.stray_at));
                    if (start) hdr_word0 = mk0(1, 0, 0, 0);
                    if (exp_i == last) begin
                        if (cnt != 511) passes--;
                        exp_i = rld;
                    end else begin
                        exp_i++;
                    end
                end else begin
                    rec_ready = 1'b0; stop = 1'b0; start = 1'b0;
                end
            end else begin
                rec_ready = 1'b0; stop = 1'b0; start = 1'b0;
            end
            if (!fin) @(negedge clk);
        end
        rec_ready = 1'b0; stop = 1'b0; start = 1'b0;
        check(fin, "R7/R8/R10 completion", $sformatf("vec %0d done seen", vi), fin, 1);
        check(n == exp_n, "R7/R8/R10 record count", $sformatf("vec %0d records", vi), n, exp_n);
        check(saw_ret == (v.stop_at == 0), (v.stop_at == 0) ? "R7 return" : "R10 no return",
              $sformatf("vec %0d ret_desc", vi), saw_ret, (v.stop_at == 0));
        check(!saw_err, "R11 no error during run", $sformatf("vec %0d cfg_err", vi), saw_err, 0);
        @(negedge clk);
        check(!busy && !done, "R7 idle after end", $sformatf("vec %0d busy/done", vi), busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !rec_valid && !done && !ret_desc && !cfg_err, "R1 reset",
              "outputs", {busy, rec_valid, done, ret_desc, cfg_err}, 0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R12: stop while idle has no effect
        @(negedge clk);
        stop = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !busy, "R12 idle stop", "done/busy", {done, busy}, 0);
        stop = 1'b0;
        run_vec(100, VECS[0]);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule